// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

A synchronous up-counter whose flip-flops all update together on the rising clock edge. A bit advances only when every bit below it is 1. In the next-state logic, each bit is XORed with a running AND of the lower bits. Three control inputs act on the clock edge: a clear that zeroes the count, a parallel load that copies a data word into the count, and a count enable. Clear takes priority over load, and load takes priority over count. An asynchronous active-low reset also zeroes the count.

A carry output is high whenever the count holds all ones. It depends only on the stored state, not on the enable. To chain two counters into a wider one, drive the upper counter's enable with the lower counter's carry ANDed with the lower counter's enable. Connect clear, load and clock to both counters. The default width is 4 bits.

Top module: `sync_bin_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0, without waiting for a clock edge.
- R2: With `clr` high at a rising edge, `count` becomes 0, whatever `ld` and `en` are.
- R3: With `clr` low and `ld` high at a rising edge, `count` takes `din`, whatever `en` is. `din[3]` (the D input) is the most significant bit and `din[0]` (the A input) is the least significant.
- R4: With `clr` and `ld` low and `en` high at a rising edge, `count` increases by one.
- R5: With `clr`, `ld` and `en` all low at a rising edge, `count` keeps its value.
- R6: Counting from all ones (15 for the 4-bit default) wraps `count` to 0.
- R7: `carry_out` is high exactly when `count` is all ones, whether or not `en` is high.
- R8: On a counting edge, bit i changes only if bits 0 through i-1 were all 1 before the edge.
- R9: Two counters chained as described form a counter twice as wide. The upper counter advances once, on the lower counter's wrap from 15 to 0, and does not advance when the lower counter holds 15 with `en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Synchronous parallel load |
| en | input | 1 | Count enable |
| din | input | WIDTH | Parallel load data, MSB first (D..A) |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High while count is all ones |

## Verification
Clear, load and count can all be requested in the same cycle. The bench raises all three controls together with load data that differs from both zero and the incremented value. The result must be zero. The bench then raises load and enable together and expects the loaded word, not an increment. A separate case tests counting and carry in the same cycle: with the lower counter at 15 and enabled, both counters update on one edge. Every case is judged against a reference value that the bench computes from the priority order.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import ctr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    ld,
  input  logic    en,
  output ctr_op_e op
);
  // clear over load, load over count
  always_comb begin
    if (clr)      op = OP_CLEAR;
    else if (ld)  op = OP_LOAD;
    else if (en)  op = OP_COUNT;
    else          op = OP_HOLD;
  end

  AST_LOAD_BEATS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld && en) |-> (op == OP_LOAD)); // R3
  AST_CLEAR_BEATS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (op == OP_CLEAR)); // R2
endmodule

// File: rtl/ctr_toggle.sv
module ctr_toggle #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] tgl,
  output logic             all_ones
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b1;
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_and
      assign chain[gi+1] = chain[gi] & q[gi];
      assign tgl[gi]     = chain[gi];
    end
  endgenerate
  assign all_ones = chain[WIDTH];
endmodule

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] tgl,
  output logic [WIDTH-1:0] nxt
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      always_comb begin
        unique case (op)
          OP_CLEAR: nxt[gi] = 1'b0;
          OP_LOAD:  nxt[gi] = din[gi];
          OP_COUNT: nxt[gi] = q[gi] ^ tgl[gi];
          default:  nxt[gi] = q[gi];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  ctr_op_e          op;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic [WIDTH-1:0] tgl;
  logic             all_ones;
  logic             q_we;

  ctr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .en(en), .op(op)
  );

  ctr_toggle #(.WIDTH(WIDTH)) u_tgl (
    .q(q_r), .tgl(tgl), .all_ones(all_ones)
  );

  ctr_next #(.WIDTH(WIDTH)) u_next (
    .op(op), .q(q_r), .din(din), .tgl(tgl), .nxt(q_nxt)
  );

  assign q_we = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= ZERO;
    else if (q_we) q_r <= q_nxt;
  end

  assign count     = q_r;
  assign carry_out = all_ones;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == ZERO)); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld) |=> (count == $past(din))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && en) |=> (count == $past(count) + ONE)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !en) |=> $stable(count)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && en && carry_out) |=> (count == ZERO)); // R6
  AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == (count == {WIDTH{1'b1}})); // R7

  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_chk
      AST_TOGGLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && !(&count[gi-1:0])) |=> (count[gi] == $past(count[gi]))); // R8
    end
  endgenerate
endmodule

// File: tb/sync_bin_counter_test.sv
module sync_bin_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, ld = 1'b0, en = 1'b0;
  logic [3:0] din_lo = 4'd0, din_hi = 4'd0;
  logic [3:0] cnt_lo, cnt_hi;
  logic       co_lo, co_hi;
  logic       en_hi;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign en_hi = co_lo & en;

  sync_bin_counter #(.WIDTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .en(en),
    .din(din_lo), .count(cnt_lo), .carry_out(co_lo)
  );
  sync_bin_counter #(.WIDTH(4)) uut_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .en(en_hi),
    .din(din_hi), .count(cnt_hi), .carry_out(co_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1ns after the next rising edge
  task automatic step(input logic c, input logic l, input logic e, input logic [7:0] d);
    @(negedge clk);
    clr = c; ld = l; en = e; din_lo = d[3:0]; din_hi = d[7:4];
    @(posedge clk); #1;
  endtask

  function automatic int full();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 reset low", full(), 0);
    chk("R7 carry at reset", co_lo, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_load();
    step(0, 1, 0, 8'hA5); chk("R3 load D..A", cnt_lo, 4'h5); chk("R3 load upper", cnt_hi, 4'hA);
    step(0, 1, 1, 8'h39); chk("R3 load beats enable", full(), 8'h39);
  endtask

  task automatic t_clear_priority();
    step(1, 1, 1, 8'h7C); chk("R2 clear beats load and enable", full(), 0);
    step(0, 1, 0, 8'h06); step(1, 0, 0, 8'h00); chk("R2 plain clear", full(), 0);
  endtask

  task automatic t_count_hold();
    int exp;
    step(0, 1, 0, 8'h02); exp = 2;
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 8'hFF); exp++;
      chk("R4 count up", cnt_lo, exp);
    end
    step(0, 0, 0, 8'hFF); chk("R5 hold", cnt_lo, exp);
    step(0, 0, 0, 8'h00); chk("R5 hold again", cnt_lo, exp);
  endtask

  task automatic t_toggle();
    // 0111 -> 1000 flips every bit; 0101 -> 0110 leaves bit3 and bit0's upper neighbours per rule
    step(0, 1, 0, 8'h05); step(0, 0, 1, 8'h00); chk("R8 0101 to 0110", cnt_lo, 6);
    step(0, 0, 1, 8'h00); chk("R8 0110 to 0111", cnt_lo, 7);
    step(0, 0, 1, 8'h00); chk("R8 0111 to 1000", cnt_lo, 8);
  endtask

  task automatic t_wrap_carry();
    step(0, 1, 0, 8'h0E); chk("R7 carry low at 14", co_lo, 0);
    step(0, 0, 1, 8'h00); chk("R7 carry high at 15", co_lo, 1);
    step(0, 0, 0, 8'h00); chk("R7 carry without enable", co_lo, 1);
    chk("R9 upper holds while lower at 15 and enable low", cnt_hi, 0);
    step(0, 0, 1, 8'h00); chk("R6 wrap to zero", cnt_lo, 0);
    chk("R9 carry into upper", cnt_hi, 1);
    chk("R7 carry drops after wrap", co_lo, 0);
  endtask

  task automatic t_cascade();
    int exp;
    step(0, 1, 0, 8'hFD); exp = 8'hFD;
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, 8'h00); exp = (exp + 1) & 8'hFF;
      chk("R9 8-bit cascade count", full(), exp);
    end
    step(0, 1, 0, 8'h20); exp = 8'h20;
    for (int i = 0; i < 40; i++) begin
      step(0, 0, (i % 3) != 1, 8'h00);
      if ((i % 3) != 1) exp = (exp + 1) & 8'hFF;
    end
    chk("R9 cascade with gaps", full(), exp);
    chk("R7 upper carry state", co_hi, (exp[7:4] == 4'hF) ? 1 : 0);
  endtask

  task automatic t_async_reset();
    step(0, 1, 0, 8'h5A);
    @(negedge clk); #1 rst_n = 1'b0; #0.5;
    chk("R1 async reset without edge", full(), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load();
    t_clear_priority();
    t_count_hold();
    t_toggle();
    t_wrap_carry();
    t_cascade();
    t_async_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule